// File: doc/BRIEF.md
# Segment LCD Timing Generator

This block produces every timing event that a segmented-LCD controller consumes, all from a single slow reference clock (typically about 32 kHz). The LCD step rate is the reference rate divided by two factors. One is a programmable divider. The other is fixed by the selected multiplex mode. From that step rate the block walks through the common phases and their polarity, marks the end of each frame, and derives a slow blink gate from the frame count. A separate prescaler and a small state machine produce four non-overlapping charge-pump phases.

Every output is an enable strobe or a level signal in the reference clock domain. No derived clock is used as a clock. Logic that builds the common and segment waveforms advances on `lcd_stb`. It blanks segments while `blk_gate` is low, and it switches the pump on the `cp_ph` levels.

The charge-pump state machine has three states. `CP_OFF` holds all phases low. `CP_GAP` holds all phases low for one pump step. `CP_DRIVE` holds exactly one phase high for one pump step. Its transitions are as follows. In `CP_OFF`, when `cp_en` rises, it goes to `CP_GAP` with the phase pointer set so that the next phase is 0. In `CP_GAP`, at the end of a step it goes to `CP_DRIVE` and advances the pointer. In `CP_DRIVE`, at the end of a step it goes to `CP_GAP`. From any state, `cp_en` low sends it to `CP_OFF`.

Top module: `lcd_timing_gen`

## Requirements
- R1: `lcd_stb` is high for one cycle every (lcd_div+1)×M cycles, where M is taken from mux_sel as follows: 0→64, 1→32, 2→16, 3→16, 4→12, 5→8, 6→8, 7→8.
- R2: A change of mux_sel or lcd_div restarts the counting. No strobe is emitted in the cycle of the change. The first `lcd_stb` is seen exactly (lcd_div+1)×M cycles after the first clock edge that samples the new value, so no runt period appears.
- R3: After a restart, `com_idx` and `com_pol` are 0. On each `lcd_stb`, `com_idx` steps 0,1,…,mux_sel and then wraps to 0, and `com_pol` inverts on each wrap.
- R4: `frame_stb` coincides with the `lcd_stb` at which `com_idx` equals mux_sel and `com_pol` is 1. This gives one frame per 2×(mux_sel+1) LCD steps.
- R5: With mux_sel=3 and lcd_div=0, the first `lcd_stb` after a restart comes at cycle 16 and the first `frame_stb` at cycle 128. For a 32768 Hz reference these are 2048 Hz and 256 Hz.
- R6: When `blk_en` is 1, `blk_gate` is 1 after a restart. It then inverts after every 2^blk_pre frame strobes, which gives a blink period of 2^(blk_pre+1) frames.
- R7: When `blk_en` is 0, `blk_gate` is 1.
- R8: When `cp_en` is enabled, the bit positions of `cp_ph` go high one at a time in the order 0,1,2,3,0,… Each phase is high for cp_sel+1 cycles. Each phase is preceded by cp_sel+1 cycles with all four bits low, the first phase included. At no time is more than one bit high.
- R9: While `cp_en` is 0, `cp_ph` is 0 from the cycle after the edge that samples it.
- R10: During reset the outputs are as follows: `lcd_stb`=0, `frame_stb`=0, `com_idx`=0, `com_pol`=0, `blk_gate`=1, `cp_ph`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mux_sel | input | 3 | Multiplex mode code (number of commons minus one) |
| lcd_div | input | DIV_W | Programmable LCD step divider (divide by value+1) |
| blk_pre | input | BLK_W | Blink prescaler exponent |
| blk_en | input | 1 | Blink enable |
| cp_sel | input | CP_W | Charge-pump step divider (divide by value+1) |
| cp_en | input | 1 | Charge-pump enable |
| lcd_stb | output | 1 | One-cycle LCD step strobe |
| frame_stb | output | 1 | One-cycle end-of-frame strobe |
| com_idx | output | 3 | Current common phase index |
| com_pol | output | 1 | Current drive polarity |
| blk_gate | output | 1 | Segment enable gate for blinking |
| cp_ph | output | 4 | Non-overlapping charge-pump phases |

## Verification
The stimulus covers every mux code, drawn at random together with small divider values. This tells apart the table entries that share a divide value (2/3, and 5/6/7) only through the length of the common sequence, and it separates table errors from errors in the divider. Before each run a changed divider value is forced, so every run begins from a restart and the first strobe position tests the no-runt rule. Random blink exponents and a blink-disabled run separate the toggle count from the gate override. Charge-pump runs with several step lengths tell a wrong rotation order, a missing gap and a wrong step length apart.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;

    localparam int MUX_W  = 3;
    localparam int MDIV_W = 7;

    typedef enum logic [1:0] {
        CP_OFF   = 2'd0,
        CP_GAP   = 2'd1,
        CP_DRIVE = 2'd2
    } cp_state_e;

    // Fixed second divide factor selected by the multiplex mode.
    function automatic logic [MDIV_W-1:0] mux_divider(input logic [MUX_W-1:0] m);
        logic [MDIV_W-1:0] r;
        case (m)
            3'd0:    r = 7'd64;
            3'd1:    r = 7'd32;
            3'd2:    r = 7'd16;
            3'd3:    r = 7'd16;
            3'd4:    r = 7'd12;
            default: r = 7'd8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcdtg_clkdiv.sv
module lcdtg_clkdiv
    import lcdtg_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MUX_W-1:0] mux_sel,
    input  logic [DIV_W-1:0] lcd_div,
    output logic             restart,
    output logic             lcd_stb,
    output logic [MUX_W-1:0] mux_q
);

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  pre_cnt;
    logic [MDIV_W-1:0] mux_cnt;
    logic [MDIV_W-1:0] mdiv;
    logic              pre_last;
    logic              mux_last;

    // Shadow copies of the configuration detect a change one edge early.
    assign restart  = (mux_sel != mux_q) || (lcd_div != div_q);
    assign mdiv     = mux_divider(mux_q);
    assign pre_last = (pre_cnt == div_q);
    assign mux_last = (mux_cnt == (mdiv - MDIV_W'(1)));
    assign lcd_stb  = !restart && pre_last && mux_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_q   <= '0;
            div_q   <= '0;
            pre_cnt <= '0;
            mux_cnt <= '0;
        end else begin
            mux_q <= mux_sel;
            div_q <= lcd_div;
            if (restart) begin
                pre_cnt <= '0;
                mux_cnt <= '0;
            end else if (pre_last) begin
                pre_cnt <= '0;
                mux_cnt <= mux_last ? '0 : mux_cnt + MDIV_W'(1);
            end else begin
                pre_cnt <= pre_cnt + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/lcdtg_phase.sv
module lcdtg_phase
    import lcdtg_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             lcd_stb,
    input  logic [MUX_W-1:0] mux_q,
    input  logic [BLK_W-1:0] blk_pre,
    input  logic             blk_en,
    output logic [MUX_W-1:0] com_idx,
    output logic             com_pol,
    output logic             frame_stb,
    output logic             blk_gate
);

    localparam int BCNT_W = 1 << BLK_W;

    logic [BCNT_W-1:0] bcnt;
    logic [BCNT_W-1:0] bterm;
    logic              bclk;
    logic              wrap;

    assign wrap      = (com_idx == mux_q);
    assign frame_stb = lcd_stb && wrap && com_pol;
    assign bterm     = (BCNT_W'(1) << blk_pre) - BCNT_W'(1);
    assign blk_gate  = !blk_en || bclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            com_idx <= '0;
            com_pol <= 1'b0;
            bcnt    <= '0;
            bclk    <= 1'b1;
        end else if (restart) begin
            com_idx <= '0;
            com_pol <= 1'b0;
            bcnt    <= '0;
            bclk    <= 1'b1;
        end else begin
            if (lcd_stb) begin
                if (wrap) begin
                    com_idx <= '0;
                    com_pol <= !com_pol;
                end else begin
                    com_idx <= com_idx + MUX_W'(1);
                end
            end
            if (frame_stb) begin
                if (bcnt >= bterm) begin
                    bcnt <= '0;
                    bclk <= !bclk;
                end else begin
                    bcnt <= bcnt + BCNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/lcdtg_cppump.sv
module lcdtg_cppump
    import lcdtg_pkg::*;
#(
    parameter int CP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cp_en,
    input  logic [CP_W-1:0] cp_sel,
    output logic [3:0]      cp_ph
);

    cp_state_e       state;
    cp_state_e       nstate;
    logic [CP_W-1:0] cnt;
    logic [1:0]      idx;
    logic            tick;

    assign tick = (cnt >= cp_sel);

    always_comb begin
        nstate = state;
        unique case (state)
            CP_OFF:   if (cp_en) nstate = CP_GAP;
            CP_GAP:   if (!cp_en) nstate = CP_OFF; else if (tick) nstate = CP_DRIVE;
            CP_DRIVE: if (!cp_en) nstate = CP_OFF; else if (tick) nstate = CP_GAP;
            default:  nstate = CP_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CP_OFF;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            idx <= 2'd3;
        end else begin
            if (state == CP_OFF || nstate != state) cnt <= '0;
            else                                    cnt <= cnt + CP_W'(1);
            if (state == CP_OFF)                         idx <= 2'd3;
            else if (state == CP_GAP && nstate == CP_DRIVE) idx <= idx + 2'd1;
        end
    end

    always_comb begin
        cp_ph = 4'b0000;
        if (state == CP_DRIVE) cp_ph = 4'b0001 << idx;
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdtg_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int BLK_W = 3,
    parameter int CP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mux_sel,
    input  logic [DIV_W-1:0] lcd_div,
    input  logic [BLK_W-1:0] blk_pre,
    input  logic             blk_en,
    input  logic [CP_W-1:0]  cp_sel,
    input  logic             cp_en,
    output logic             lcd_stb,
    output logic             frame_stb,
    output logic [2:0]       com_idx,
    output logic             com_pol,
    output logic             blk_gate,
    output logic [3:0]       cp_ph
);

    logic             restart;
    logic [MUX_W-1:0] mux_q;

    lcdtg_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .mux_sel (mux_sel),
        .lcd_div (lcd_div),
        .restart (restart),
        .lcd_stb (lcd_stb),
        .mux_q   (mux_q)
    );

    lcdtg_phase #(.BLK_W(BLK_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .lcd_stb   (lcd_stb),
        .mux_q     (mux_q),
        .blk_pre   (blk_pre),
        .blk_en    (blk_en),
        .com_idx   (com_idx),
        .com_pol   (com_pol),
        .frame_stb (frame_stb),
        .blk_gate  (blk_gate)
    );

    lcdtg_cppump #(.CP_W(CP_W)) u_cp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cp_en  (cp_en),
        .cp_sel (cp_sel),
        .cp_ph  (cp_ph)
    );

endmodule

// File: rtl/lcdtg_chk.sv
module lcdtg_chk #(
    parameter int DIV_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mux_sel,
    input logic [DIV_W-1:0] lcd_div,
    input logic             blk_en,
    input logic             cp_en,
    input logic             lcd_stb,
    input logic             frame_stb,
    input logic [2:0]       com_idx,
    input logic             com_pol,
    input logic             blk_gate,
    input logic [3:0]       cp_ph
);

    // R2
    no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != $past(mux_sel) || lcd_div != $past(lcd_div)) |-> !lcd_stb);

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_stb |-> (com_idx <= mux_sel));

    // R4
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (lcd_stb && com_pol && com_idx == mux_sel));

    // R7
    blink_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |-> blk_gate);

    // R8
    cp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cp_ph));

    // R8
    cp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_ph != 4'd0) |=> (cp_ph == $past(cp_ph) || cp_ph == 4'd0));

    // R9
    cp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_en |=> (cp_ph == 4'd0));

endmodule

bind lcd_timing_gen lcdtg_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mux_sel   (mux_sel),
    .lcd_div   (lcd_div),
    .blk_en    (blk_en),
    .cp_en     (cp_en),
    .lcd_stb   (lcd_stb),
    .frame_stb (frame_stb),
    .com_idx   (com_idx),
    .com_pol   (com_pol),
    .blk_gate  (blk_gate),
    .cp_ph     (cp_ph)
);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;

    localparam int DIV_W = 4;
    localparam int BLK_W = 3;
    localparam int CP_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mux_sel = '0;
    logic [DIV_W-1:0] lcd_div = '0;
    logic [BLK_W-1:0] blk_pre = '0;
    logic             blk_en = 1'b1;
    logic [CP_W-1:0]  cp_sel = '0;
    logic             cp_en = 1'b0;
    logic             lcd_stb, frame_stb, com_pol, blk_gate;
    logic [2:0]       com_idx;
    logic [3:0]       cp_ph;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = !clk;

    lcd_timing_gen #(.DIV_W(DIV_W), .BLK_W(BLK_W), .CP_W(CP_W)) dut (
        .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .lcd_div(lcd_div),
        .blk_pre(blk_pre), .blk_en(blk_en), .cp_sel(cp_sel), .cp_en(cp_en),
        .lcd_stb(lcd_stb), .frame_stb(frame_stb), .com_idx(com_idx),
        .com_pol(com_pol), .blk_gate(blk_gate), .cp_ph(cp_ph)
    );

    function automatic int ref_mdiv(input int m);
        case (m)
            0: return 64;
            1: return 32;
            2, 3: return 16;
            4: return 12;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            if (n_bad < 20) $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Applies a configuration (forcing a restart) and checks R1..R4, R6, R7 cycle by cycle.
    task automatic lcd_run(input int m, input int d, input int p, input bit ben, input int nframes);
        int per, total, s, ei, ep, fc;
        bit es, ef, b;
        @(negedge clk);
        mux_sel = 3'(m); lcd_div = DIV_W'(d ^ 1); blk_pre = BLK_W'(p); blk_en = ben;
        @(negedge clk);
        lcd_div = DIV_W'(d);
        per = (d + 1) * ref_mdiv(m);
        total = per * 2 * (m + 1) * nframes;
        b = 1; fc = 0;
        for (int c = 1; c <= total; c++) begin
            @(negedge clk);
            s  = (c - 1) / per;
            ei = s % (m + 1);
            ep = (s / (m + 1)) % 2;
            es = (c % per) == 0;
            ef = es && (ei == m) && (ep == 1);
            chk(lcd_stb == es, (c <= per) ? "R2 first strobe" : "R1 strobe", lcd_stb, es);
            chk(com_idx == 3'(ei), "R3 com_idx", com_idx, ei);
            chk(com_pol == ep[0], "R3 com_pol", com_pol, ep);
            chk(frame_stb == ef, "R4 frame_stb", frame_stb, ef);
            chk(blk_gate == (!ben || b), ben ? "R6 blk_gate" : "R7 blk_gate", blk_gate, (!ben || b));
            if (ef) begin
                fc++;
                if (fc == (1 << p)) begin fc = 0; b = !b; end
            end
        end
    endtask

    task automatic cp_run(input int sel, input int ncyc);
        int len, j;
        logic [3:0] e;
        @(negedge clk);
        cp_en = 1'b0; cp_sel = CP_W'(sel);
        @(negedge clk);
        cp_en = 1'b1;
        len = sel + 1;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            j = (c - 1) / len;
            e = (j % 2 == 1) ? (4'b0001 << (((j - 1) / 2) % 4)) : 4'b0000;
            chk(cp_ph == e, "R8 cp_ph", cp_ph, e);
        end
        cp_en = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(cp_ph == 4'b0000, "R9 cp off", cp_ph, 0);
        end
    endtask

    task automatic directed_r5();
        int first_l, first_f, c;
        @(negedge clk);
        mux_sel = 3'd3; lcd_div = DIV_W'(1); blk_en = 1'b1;
        @(negedge clk);
        lcd_div = '0;
        first_l = 0; first_f = 0; c = 0;
        while (first_f == 0 && c < 1000) begin
            @(negedge clk);
            c++;
            if (lcd_stb && first_l == 0) first_l = c;
            if (frame_stb) first_f = c;
        end
        chk(first_l == 16, "R5 first lcd strobe", first_l, 16);
        chk(first_f == 128, "R5 first frame", first_f, 128);
    endtask

    initial begin
        int m, d, p;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(lcd_stb == 1'b0,   "R10 lcd_stb",   lcd_stb, 0);
        chk(frame_stb == 1'b0, "R10 frame_stb", frame_stb, 0);
        chk(com_idx == 3'd0,   "R10 com_idx",   com_idx, 0);
        chk(com_pol == 1'b0,   "R10 com_pol",   com_pol, 0);
        chk(blk_gate == 1'b1,  "R10 blk_gate",  blk_gate, 1);
        chk(cp_ph == 4'd0,     "R10 cp_ph",     cp_ph, 0);
        rst_n = 1'b1;

        directed_r5();
        lcd_run(7, 0, 2, 1'b1, 9);
        lcd_run(0, 0, 0, 1'b1, 3);
        lcd_run(5, 1, 0, 1'b0, 3);
        for (int i = 0; i < 8; i++) begin
            m = int'($urandom % 8);
            d = int'($urandom % 4);
            p = int'($urandom % 3);
            lcd_run(m, d, p, 1'b1, 2 * (1 << p) + 1);
        end

        cp_run(0, 40);
        cp_run(3, 80);
        for (int i = 0; i < 3; i++) cp_run(int'($urandom % 8), 100);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0 (run did not complete)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule